// File: doc/BRIEF.md
# Speculative Transaction Buffer Controller

This unit sits beside one processor and lets it run a single optimistic transaction at a time. Between a begin pulse and an end pulse, every load sets a read mark on the local cache line slot it falls in. Every store is parked in a small local write buffer and stays invisible to the rest of the system. Meanwhile the unit watches a shared commit bus on which other processors publish their committed addresses. A published address that lands on a marked slot means the transaction consumed stale inputs. The unit then raises a one-cycle violation, drops all speculative state and returns to idle so that the core can retry.

When the transaction ends cleanly, the unit asks the bus arbiter for its turn. Once granted, it publishes the buffered writes back to back while it holds the bus, so other processors observe them as one indivisible update. A transaction that performed no stores finishes at once, without asking for the bus. If the buffer runs out of room, the unit stops speculating. It keeps the store that overflowed in a spare slot, stalls the core, commits everything it holds as soon as it is granted, and then lets the transaction continue from an empty buffer.

Line slots are chosen by address bits: slot = (addr >> LINE_OFF_W) mod 2^SLOT_W. Marks are kept per slot, so two lines that share a slot alias conservatively. A snoop to either line counts as a conflict.

Top module: `txn_spec_ctrl`

## Requirements
- R1: After reset, violation, busy, ovf, tx_done, commit_req and commit_valid are all 0.
- R2: In the running state, a snoop whose slot (address bits [LINE_OFF_W+SLOT_W-1:LINE_OFF_W], default bits [5:2]) matches a slot marked by an earlier load, or by a load in the same cycle, raises violation in the next cycle. Violation holds for exactly one cycle, and the unit is idle in the cycle after.
- R3: A snoop whose slot carries no mark has no effect; violation stays 0.
- R4: A violation clears every read mark and empties the write buffer. In the next transaction, a snoop to a formerly marked slot is harmless, and a load of a formerly buffered address is not forwarded.
- R5: A load of an address that is held in the write buffer returns the buffered data with ld_fwd=1. Any other load returns ld_fill with ld_fwd=0, in the same cycle. A repeated store to a buffered address replaces that entry's data and does not add an entry.
- R6: commit_valid stays 0 until the grant. After tx_end with buffered stores, commit_req is 1 from the next cycle onward. The cycle after commit_grant is seen, commit_valid is 1 for N consecutive cycles, one entry per cycle in first-store order, carrying each address's latest data. commit_req falls after the last beat.
- R7: While the unit waits for the grant, a snoop that hits a marked slot causes a violation. A snoop in the same cycle as the grant, or during the commit beats, causes none.
- R8: tx_end in a transaction with no stores gives tx_done=1 in the next cycle and never raises commit_req.
- R9: A store to a new address when WB_DEPTH entries are already held is kept. In the next cycle ovf, busy and commit_req are 1. After the grant, WB_DEPTH+1 beats are published, and the unit then returns to the running state with ovf=0 and busy=0, without tx_done.
- R10: tx_done pulses for one cycle, in the cycle after the last beat of an ending transaction's commit.
- R11: Loads, stores, snoops and tx_end are ignored while idle. A store issued while idle is never published.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Start a transaction (accepted when idle) |
| tx_end | input | 1 | Finish the running transaction |
| ld_valid | input | 1 | Load request this cycle |
| ld_addr | input | ADDR_W | Load word address |
| ld_fill | input | DATA_W | Value supplied for the load by the lower level |
| ld_data | output | DATA_W | Load result (buffered value or ld_fill) |
| ld_fwd | output | 1 | Load result came from the write buffer |
| st_valid | input | 1 | Store request this cycle |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| violation | output | 1 | One-cycle rollback indication; state is being cleared |
| busy | output | 1 | Core must stall (waiting for, or doing, a commit or rollback) |
| ovf | output | 1 | Buffer overflowed; early commit pending |
| tx_done | output | 1 | One-cycle pulse: transaction completed |
| commit_req | output | 1 | Request for, and hold of, the commit bus |
| commit_grant | input | 1 | Arbiter grant of the commit bus |
| commit_valid | output | 1 | Commit beat valid |
| commit_addr | output | ADDR_W | Commit beat address |
| commit_data | output | DATA_W | Commit beat data |
| snp_valid | input | 1 | Another unit's commit beat seen on the bus |
| snp_addr | input | ADDR_W | Address of the snooped commit beat |

## Verification
The assertions assume that the core obeys busy. While busy is high, it issues no loads, stores, tx_end or tx_begin, and it never pairs tx_end with a load, a store or an overflowing store. They also assume that the arbiter keeps commit_grant high for the whole run of commit beats. The stimulus respects these rules by construction. Each operation is one task that starts only after the previous one has finished, including any early commit it triggered. The grant is raised at the start of a commit and dropped only after the last expected beat. Snoops during commit beats are random, while snoops during the grant wait are steered to unmarked slots, except in the directed case that aims to abort there.

// File: rtl/txs_pkg.sv
package txs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_DRAIN = 3'd3,
    ST_ABORT = 3'd4
  } txs_state_e;

  // Slot a word address falls in: drop the in-line offset, keep the low slot bits.
  function automatic int line_slot(input logic [63:0] addr, input int off_w, input int slot_w);
    logic [63:0] shifted;
    logic [63:0] mask;
    shifted = addr >> off_w;
    mask    = (64'd1 << slot_w) - 64'd1;
    return int'(shifted & mask);
  endfunction

endpackage

// File: rtl/txs_read_set.sv
module txs_read_set #(
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              mark_en,
  input  logic [SLOT_W-1:0] mark_slot,
  input  logic [SLOT_W-1:0] probe_slot,
  output logic              probe_hit
);
  localparam int NSLOT = 1 << SLOT_W;

  logic [NSLOT-1:0] marks;
  logic             same_cycle_hit;

  assign same_cycle_hit = mark_en && (mark_slot == probe_slot);
  assign probe_hit      = marks[probe_slot] || same_cycle_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      marks <= '0;
    end else if (clr) begin
      marks <= '0;
    end else if (mark_en) begin
      marks[mark_slot] <= 1'b1;
    end
  end

  // R4: a clear leaves no mark behind
  a_r4_marks_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (marks == '0));

endmodule

// File: rtl/txs_write_buf.sv
module txs_write_buf #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int WB_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              drain_adv,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  output logic              wr_hit,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W-1:0] drain_addr,
  output logic [DATA_W-1:0] drain_data,
  output logic              drain_last
);
  localparam int SLOTS = WB_DEPTH + 1;        // one spare slot for the overflowing store
  localparam int CW    = $clog2(SLOTS + 1);
  localparam int PW    = $clog2(SLOTS);

  logic [ADDR_W-1:0] slot_addr [SLOTS];
  logic [DATA_W-1:0] slot_data [SLOTS];
  logic [SLOTS-1:0]  slot_vld;
  logic [SLOTS-1:0]  lk_match;
  logic [SLOTS-1:0]  wr_match;
  logic [CW-1:0]     cnt;
  logic [PW-1:0]     ptr;
  logic              alloc;

  assign alloc = wr_en && !(|wr_match) && (cnt < CW'(SLOTS));

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign lk_match[i] = slot_vld[i] && (slot_addr[i] == lk_addr);
    assign wr_match[i] = slot_vld[i] && (slot_addr[i] == wr_addr);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_vld[i]  <= 1'b0;
        slot_addr[i] <= '0;
        slot_data[i] <= '0;
      end else if (clr) begin
        slot_vld[i]  <= 1'b0;
      end else if (alloc && (cnt == CW'(i))) begin
        slot_vld[i]  <= 1'b1;
        slot_addr[i] <= wr_addr;
        slot_data[i] <= wr_data;
      end else if (wr_en && wr_match[i]) begin
        slot_data[i] <= wr_data;
      end
    end
  end

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (lk_match[i]) lk_data = lk_data | slot_data[i];
    end
  end

  assign lk_hit     = |lk_match;
  assign wr_hit     = |wr_match;
  assign full       = (cnt == CW'(WB_DEPTH));
  assign empty      = (cnt == '0);
  assign drain_addr = slot_addr[ptr];
  assign drain_data = slot_data[ptr];
  assign drain_last = ((CW'(ptr) + CW'(1)) == cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ptr <= '0;
    end else if (clr) begin
      cnt <= '0;
      ptr <= '0;
    end else begin
      if (alloc)     cnt <= cnt + CW'(1);
      if (drain_adv) ptr <= ptr + PW'(1);
    end
  end

  // R9: never more entries than the slots that exist
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(SLOTS));
  // R5: coalescing keeps each address in at most one entry
  a_r5_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_match));
  // R6: beats only walk over filled entries
  a_r6_drain_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    drain_adv |-> (CW'(ptr) < cnt));

endmodule

// File: rtl/txs_fsm.sv
module txs_fsm
  import txs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_begin,
  input  logic       tx_end,
  input  logic       st_valid,
  input  logic       st_new_full,
  input  logic       buf_empty,
  input  logic       snoop_hit,
  input  logic       commit_grant,
  input  logic       drain_last,
  output txs_state_e state,
  output logic       ovf_q,
  output logic       done_q,
  output logic       viol_now,
  output logic       clr_now
);
  logic running, waiting, draining, ro_finish, spill;

  assign running  = (state == ST_RUN);
  assign waiting  = (state == ST_WAIT);
  assign draining = (state == ST_DRAIN);

  // A snoop after the grant is our own commit window: never a violation.
  assign viol_now  = snoop_hit && (running || (waiting && !commit_grant));
  assign spill     = running && !viol_now && st_valid && st_new_full;
  assign ro_finish = running && !viol_now && !spill && tx_end && buf_empty && !st_valid;
  assign clr_now   = (state == ST_ABORT) || (draining && drain_last) || ro_finish;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (tx_begin) state <= ST_RUN;
        ST_RUN: begin
          if (viol_now) begin
            state <= ST_ABORT;
          end else if (spill) begin
            state <= ST_WAIT;
            ovf_q <= 1'b1;
          end else if (ro_finish) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else if (tx_end) begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (viol_now) begin
            state <= ST_ABORT;
            ovf_q <= 1'b0;
          end else if (commit_grant) begin
            state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (drain_last) begin
            state  <= ovf_q ? ST_RUN : ST_IDLE;
            done_q <= !ovf_q;
            ovf_q  <= 1'b0;
          end
        end
        ST_ABORT: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R2: rollback lasts one cycle and lands in idle
  a_r2_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ABORT) |=> (state == ST_IDLE));
  // R7: once draining, no rollback can follow
  a_r7_no_abort_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN) |=> (state != ST_ABORT));
  // R7: grant wins over a same-cycle snoop
  a_r7_grant_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && commit_grant) |=> (state == ST_DRAIN));

endmodule

// File: rtl/txn_spec_ctrl.sv
module txn_spec_ctrl
  import txs_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LINE_OFF_W = 2,
  parameter int SLOT_W     = 4,
  parameter int WB_DEPTH   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_begin,
  input  logic              tx_end,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_fill,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_fwd,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              violation,
  output logic              busy,
  output logic              ovf,
  output logic              tx_done,
  output logic              commit_req,
  input  logic              commit_grant,
  output logic              commit_valid,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr
);
  txs_state_e        state;
  logic              ovf_q, done_q, viol_now, clr_now;
  logic              running, mark_en, wr_en, probe_hit, snoop_hit;
  logic              lk_hit, wr_hit, full, empty, drain_last;
  logic [DATA_W-1:0] lk_data;
  logic [SLOT_W-1:0] ld_slot, snp_slot;

  assign running   = (state == ST_RUN);
  assign ld_slot   = SLOT_W'(line_slot(64'(ld_addr), LINE_OFF_W, SLOT_W));
  assign snp_slot  = SLOT_W'(line_slot(64'(snp_addr), LINE_OFF_W, SLOT_W));
  assign mark_en   = running && ld_valid;
  assign snoop_hit = snp_valid && probe_hit;
  assign wr_en     = running && st_valid && !viol_now;

  txs_read_set #(.SLOT_W(SLOT_W)) u_rset (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_now),
    .mark_en   (mark_en),
    .mark_slot (ld_slot),
    .probe_slot(snp_slot),
    .probe_hit (probe_hit)
  );

  txs_write_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WB_DEPTH(WB_DEPTH)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_now),
    .wr_en     (wr_en),
    .wr_addr   (st_addr),
    .wr_data   (st_data),
    .lk_addr   (ld_addr),
    .drain_adv (state == ST_DRAIN),
    .lk_hit    (lk_hit),
    .lk_data   (lk_data),
    .wr_hit    (wr_hit),
    .full      (full),
    .empty     (empty),
    .drain_addr(commit_addr),
    .drain_data(commit_data),
    .drain_last(drain_last)
  );

  txs_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_begin    (tx_begin),
    .tx_end      (tx_end),
    .st_valid    (st_valid),
    .st_new_full (!wr_hit && full),
    .buf_empty   (empty),
    .snoop_hit   (snoop_hit),
    .commit_grant(commit_grant),
    .drain_last  (drain_last),
    .state       (state),
    .ovf_q       (ovf_q),
    .done_q      (done_q),
    .viol_now    (viol_now),
    .clr_now     (clr_now)
  );

  assign ld_fwd       = ld_valid && lk_hit;
  assign ld_data      = ld_fwd ? lk_data : ld_fill;
  assign violation    = (state == ST_ABORT);
  assign busy         = (state == ST_WAIT) || (state == ST_DRAIN) || (state == ST_ABORT);
  assign ovf          = ovf_q;
  assign tx_done      = done_q;
  assign commit_req   = (state == ST_WAIT) || (state == ST_DRAIN);
  assign commit_valid = (state == ST_DRAIN);

  // R6: beats only while the bus is held
  a_r6_beat_under_req: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> commit_req);
  // R9: an overflow always stalls the core
  a_r9_ovf_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> busy);
  // R2: violation is a single-cycle pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> !violation);
  // R10: completion is never reported together with a live commit
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !commit_req);

endmodule

// File: tb/txn_spec_ctrl_bench.sv
`timescale 1ns/1ps
module txn_spec_ctrl_bench;
  localparam int AW = 16, DW = 32, DEP = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, tx_begin, tx_end, ld_valid, st_valid, snp_valid, commit_grant;
  logic [AW-1:0] ld_addr, st_addr, snp_addr, commit_addr;
  logic [DW-1:0] ld_fill, st_data, ld_data, commit_data;
  logic ld_fwd, violation, busy, ovf, tx_done, commit_req, commit_valid;

  txn_spec_ctrl u_txn_spec_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_end(tx_end),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_fill(ld_fill), .ld_data(ld_data),
    .ld_fwd(ld_fwd), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .violation(violation), .busy(busy), .ovf(ovf), .tx_done(tx_done),
    .commit_req(commit_req), .commit_grant(commit_grant), .commit_valid(commit_valid),
    .commit_addr(commit_addr), .commit_data(commit_data),
    .snp_valid(snp_valid), .snp_addr(snp_addr)
  );

  int nchk = 0, nerr = 0;
  bit mk [16];
  int mcnt = 0;
  logic [AW-1:0] ma [DEP+1];
  logic [DW-1:0] md [DEP+1];
  bit g_abort = 0;
  bit finished = 0;

  function automatic int slot_of(logic [AW-1:0] a);
    return (int'(a) / 4) % 16;
  endfunction

  function automatic int find(logic [AW-1:0] a);
    for (int i = 0; i < mcnt; i++) if (ma[i] == a) return i;
    return -1;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear;
    mcnt = 0;
    for (int i = 0; i < 16; i++) mk[i] = 0;
  endtask

  task automatic quiet;
    tx_begin = 0; tx_end = 0; ld_valid = 0; st_valid = 0; snp_valid = 0;
    ld_addr = '0; st_addr = '0; snp_addr = '0; ld_fill = '0; st_data = '0;
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  // grant in the waiting cycle, with a snoop that must be ignored (R7)
  task automatic do_drain(bit from_ovf, logic [AW-1:0] first_snp);
    int n;
    n = mcnt;
    commit_grant = 1; snp_valid = 1; snp_addr = first_snp;
    step;
    for (int i = 0; i < n; i++) begin
      snp_addr = AW'($urandom % 256); #1;
      chk("R6 beat valid", commit_valid, 1);
      chk("R6 beat addr", commit_addr, ma[i]);
      chk("R6 beat data", commit_data, md[i]);
      chk("R7 no violation while committing", violation, 0);
      step;
    end
    commit_grant = 0; snp_valid = 0; #1;
    chk("R6 commit_valid falls", commit_valid, 0);
    chk("R6 commit_req falls", commit_req, 0);
    chk("R10 tx_done after last beat", tx_done, !from_ovf);
    chk("R9 ovf cleared", ovf, 0);
    chk("R7 no violation after grant", violation, 0);
    model_clear;
  endtask

  task automatic cycle(bit ld, logic [AW-1:0] la, bit st, logic [AW-1:0] sa,
                       logic [DW-1:0] sd, bit sp, logic [AW-1:0] spa);
    int f, sf;
    bit viol, ov;
    logic [DW-1:0] fill;
    fill = $urandom;
    ld_valid = ld; ld_addr = la; ld_fill = fill;
    st_valid = st; st_addr = sa; st_data = sd;
    snp_valid = sp; snp_addr = spa;
    #1;
    if (ld) begin
      f = find(la);
      chk("R5 forward flag", ld_fwd, (f >= 0));
      chk("R5 load data", ld_data, (f >= 0) ? md[f] : fill);
    end
    viol = sp && (mk[slot_of(spa)] || (ld && slot_of(la) == slot_of(spa)));
    sf = st ? find(sa) : -1;
    ov = !viol && st && sf < 0 && mcnt == DEP;
    step;
    quiet;
    #1;
    if (viol) begin
      chk("R2 violation raised", violation, 1);
      chk("R2 busy during rollback", busy, 1);
      step;
      chk("R2 violation one cycle", violation, 0);
      chk("R2 idle after rollback", commit_req, 0);
      model_clear;
      g_abort = 1;
    end else begin
      chk("R3 no violation", violation, 0);
      if (ld) mk[slot_of(la)] = 1;
      if (st) begin
        if (sf >= 0) md[sf] = sd;
        else begin ma[mcnt] = sa; md[mcnt] = sd; mcnt++; end
      end
      if (ov) begin
        chk("R9 ovf raised", ovf, 1);
        chk("R9 busy on overflow", busy, 1);
        chk("R9 early commit request", commit_req, 1);
        step;
        chk("R9 ovf held until grant", ovf, 1);
        do_drain(1, AW'($urandom % 256));
        chk("R9 running again", busy, 0);
      end
    end
  endtask

  task automatic begin_tx;
    tx_begin = 1; step; tx_begin = 0; g_abort = 0;
  endtask

  task automatic end_tx;
    int waits;
    tx_end = 1; step; tx_end = 0; #1;
    if (mcnt == 0) begin
      chk("R8 tx_done read-only", tx_done, 1);
      chk("R8 no commit request", commit_req, 0);
      model_clear;
      step;
      chk("R10 tx_done one cycle", tx_done, 0);
    end else begin
      chk("R6 commit_req after end", commit_req, 1);
      chk("R6 nothing visible before grant", commit_valid, 0);
      waits = $urandom % 3;
      for (int w = 0; w < waits; w++) begin
        for (int s = 0; s < 16; s++) begin
          if (!mk[s]) begin
            snp_valid = 1;
            snp_addr = AW'(s * 4 + 64 * ($urandom % 4));
            break;
          end
        end
        step; snp_valid = 0; #1;
        chk("R3 unmarked snoop while waiting", violation, 0);
        chk("R6 request held", commit_req, 1);
      end
      do_drain(0, AW'($urandom % 256));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    quiet; commit_grant = 0; rst_n = 0;
    model_clear;
    repeat (3) @(posedge clk);
    #1; rst_n = 1; #1;
    chk("R1 violation", violation, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 tx_done", tx_done, 0);
    chk("R1 commit_req", commit_req, 0);
    chk("R1 commit_valid", commit_valid, 0);

    // R11: idle ignores stores, snoops and tx_end
    st_valid = 1; st_addr = 16'h0030; st_data = 32'hDEAD0001;
    snp_valid = 1; snp_addr = 16'h0030; tx_end = 1;
    step; quiet; #1;
    chk("R11 no violation in idle", violation, 0);
    chk("R11 tx_end ignored in idle", tx_done, 0);
    begin_tx; end_tx;   // store in idle must not be published

    // R5 coalescing and forwarding
    begin_tx;
    cycle(0, 0, 1, 16'h0014, 32'h11, 0, 0);
    cycle(0, 0, 1, 16'h0014, 32'h22, 0, 0);
    cycle(0, 0, 1, 16'h0080, 32'h33, 0, 0);
    cycle(1, 16'h0014, 0, 0, 0, 0, 0);
    cycle(1, 16'h0090, 0, 0, 0, 0, 0);
    end_tx;

    // R2 / R4: abort, then clean slate
    begin_tx;
    cycle(0, 0, 1, 16'h0200, 32'h44, 0, 0);
    cycle(1, 16'h0040, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 1, 16'h0100);       // same slot as 0x40
    begin_tx;
    cycle(0, 0, 0, 0, 0, 1, 16'h0040);       // R4 old mark gone
    cycle(1, 16'h0200, 0, 0, 0, 0, 0);       // R4 no stale forward
    end_tx;

    // R2 same-cycle load and snoop on one slot
    begin_tx;
    cycle(1, 16'h0004, 0, 0, 0, 1, 16'h0044);

    // R7 snoop while waiting without grant
    begin_tx;
    cycle(1, 16'h0008, 0, 0, 0, 0, 0);
    cycle(0, 0, 1, 16'h0020, 32'h55, 0, 0);
    tx_end = 1; step; tx_end = 0;
    snp_valid = 1; snp_addr = 16'h0048; step; quiet; #1;
    chk("R7 violation while waiting", violation, 1);
    step;
    chk("R7 idle after rollback", commit_req, 0);
    model_clear;

    // R7 snoop with grant in the same cycle: commit proceeds
    begin_tx;
    cycle(1, 16'h0008, 0, 0, 0, 0, 0);
    cycle(0, 0, 1, 16'h0020, 32'h66, 0, 0);
    tx_end = 1; step; tx_end = 0;
    do_drain(0, 16'h0048);

    // R9 overflow then continue
    begin_tx;
    for (int i = 0; i <= DEP; i++) cycle(0, 0, 1, AW'(16'h0300 + i * 4), DW'(i + 100), 0, 0);
    cycle(0, 0, 1, 16'h0400, 32'h77, 0, 0);
    end_tx;

    // random transactions
    for (int t = 0; t < 80; t++) begin
      int n;
      begin_tx;
      n = 4 + $urandom % 14;
      for (int k = 0; k < n && !g_abort; k++) begin
        cycle(($urandom % 3) == 0, AW'(($urandom % 48) * 2),
              ($urandom % 2) == 0, AW'(($urandom % 48) * 2), $urandom,
              ($urandom % 8) == 0, AW'(($urandom % 96) * 2));
      end
      if (!g_abort) end_tx;
    end
    summary;
  end
endmodule